// File: doc/BRIEF.md
# Indirect Bus Access Command Bridge

This block lets a wide 64-bit register port reach a narrower 32-bit internal peripheral bus one access at a time. Software first loads a 32-bit data value through the control port, which places it in the upper half of the control word. It then writes a command word that gives the direction, a byte count of one to four and a 32-bit address. The bridge runs a single request/response exchange on the internal bus and returns the outcome through a status word.

The status word carries a done flag, three error flags and, after a successful read, the returned bytes. Reading the status word clears it, so each completion is seen exactly once. A busy flag is merged into every status read while an access is outstanding. Command writes that arrive during that time are dropped. Byte lanes are big-endian: byte 0 of a transfer always sits in bits 31:24 of the 32-bit data.

Top module: `ibb_bridge`

## Requirements
- R1: After reset the status word reads zero, the data register reads zero and `req_valid` is low.
- R2: A control write with `ctl_sel`=0 stores `ctl_wdata[63:32]` in the data register. A control read with `ctl_sel`=0 returns that value in bits 63:32 and zero in bits 31:0.
- R3: A control write with `ctl_sel`=1 and a legal size, made while idle, starts exactly one request. Command bit 63 selects write (1) or read (0), bits 50:48 give the byte count and bits 31:0 give the address. `req_valid` rises one cycle after the command edge and holds, with stable fields, until `req_ready`.
- R4: On a write the data register is sent most significant byte first: byte 0 in `req_wdata[31:24]`, byte 3 in `req_wdata[7:0]`. Lanes at or beyond the byte count are zero, and a read request carries zero data.
- R5: A finished access sets status bit 63 (done). A read that completes without error puts the returned data in status bits 31:0, with lanes at or beyond the byte count zeroed. A write leaves those bits zero.
- R6: A control read with `ctl_sel`=2 returns the status word and clears it at that edge, unless an access finishes at the same edge.
- R7: A byte count of 0 or of 5 to 7 finishes on the command edge with done and the size-error flag (bit 60) set, and issues no request.
- R8: A response with `rsp_err` high sets the bus-error flag (bit 62), and status bits 31:0 stay zero.
- R9: If no response arrives within `TIMEOUT` cycles of the command edge, the access ends with done and the timeout flag (bit 61) set, and `req_valid` drops.
- R10: While an access is outstanding, status reads show the busy flag (bit 59). Command writes made during that time are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_rd | input | 1 | Control-port read strobe (clears status when `ctl_sel`=2) |
| ctl_sel | input | 2 | Register select: 0 data, 1 command, 2 status |
| ctl_wdata | input | 64 | Control write value |
| ctl_rdata | output | 64 | Control read value for the selected register |
| req_valid | output | 1 | Internal-bus request valid |
| req_ready | input | 1 | Internal-bus request accepted |
| req_write | output | 1 | Request direction, 1 = write |
| req_addr | output | 32 | Request address |
| req_size | output | 3 | Request byte count, 1 to 4 |
| req_wdata | output | 32 | Write data, byte 0 in bits 31:24 |
| rsp_valid | input | 1 | Response valid |
| rsp_err | input | 1 | Response error |
| rsp_rdata | input | 32 | Read data, byte 0 in bits 31:24 |

## Verification
The command is taken at the clock edge that registers the control write. The request is then visible in the next cycle, and the status word changes at the edge that registers `rsp_valid`. A size error shows in status one edge after the command. A timeout lands on the `TIMEOUT`-th edge after the command. The bench drives every input on the falling edge, and a responder model checks each request against a queue of expected requests when it raises `req_ready`. Status is read only after the response delay plus a margin, or, for the busy checks, well before the earliest possible finish.

// File: rtl/ibb_pkg.sv
package ibb_pkg;
    localparam int unsigned CTL_W   = 64;
    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned SZ_W    = 3;
    // command field positions
    localparam int unsigned CMD_WR  = 63;
    localparam int unsigned CMD_SZ  = 48;
    // status flag positions
    localparam int unsigned ST_DONE = 63;
    localparam int unsigned ST_BERR = 62;
    localparam int unsigned ST_TOUT = 61;
    localparam int unsigned ST_SZE  = 60;
    localparam int unsigned ST_BUSY = 59;

    typedef enum logic [1:0] {SEL_DATA = 2'd0, SEL_CMD = 2'd1, SEL_STAT = 2'd2} sel_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_REQ = 2'd1, ST_RSP = 2'd2} state_e;

    typedef struct packed {
        logic              write;
        logic [SZ_W-1:0]   size;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } op_t;

    typedef struct packed {
        state_e            st;
        op_t               op;
        logic [DATA_W-1:0] data;
        logic [CTL_W-1:0]  stat;
    } regs_t;
endpackage

// File: rtl/ibb_lane_mask.sv
module ibb_lane_mask #(
    parameter int unsigned LANES = 4,
    parameter int unsigned SZ_W  = 3
) (
    input  logic [SZ_W-1:0]    size,
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] dout
);
    // lane i (byte i) lives at the i-th byte from the top; kept when i < size
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[8*(LANES-i)-1 -: 8] = (size > SZ_W'(i)) ? din[8*(LANES-i)-1 -: 8] : 8'h00;
    end
endmodule

// File: rtl/ibb_timer.sv
module ibb_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CW = $clog2(LIMIT) + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic          at_lim;

    always_comb begin
        at_lim = (cnt_q >= CW'(LIMIT - 1));
        expire = run && at_lim;
        if (!run)        cnt_d = '0;
        else if (at_lim) cnt_d = cnt_q;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));
endmodule

// File: rtl/ibb_bridge.sv
module ibb_bridge
    import ibb_pkg::*;
#(
    parameter int unsigned TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [1:0]        ctl_sel,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [SZ_W-1:0]   req_size,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rsp_rdata
);
    regs_t             d, q;
    logic              busy, expire, fin, cmd_hit, size_ok, stat_rd;
    logic [SZ_W-1:0]   cmd_size;
    logic [CTL_W-1:0]  fin_stat;
    logic [DATA_W-1:0] rd_masked;
    logic              unused_cmd_bits;

    assign unused_cmd_bits = ^{ctl_wdata[62:51], ctl_wdata[47:32]};

    ibb_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .expire(expire)
    );

    ibb_lane_mask #(.LANES(LANES), .SZ_W(SZ_W)) u_wmask (
        .size(q.op.size), .din(q.op.wdata), .dout(req_wdata)
    );

    ibb_lane_mask #(.LANES(LANES), .SZ_W(SZ_W)) u_rmask (
        .size(q.op.size), .din(rsp_rdata), .dout(rd_masked)
    );

    assign busy      = (q.st != ST_IDLE);
    assign req_valid = (q.st == ST_REQ);
    assign req_write = q.op.write;
    assign req_addr  = q.op.addr;
    assign req_size  = q.op.size;

    always_comb begin
        d        = q;
        fin      = 1'b0;
        fin_stat = '0;
        cmd_size = ctl_wdata[CMD_SZ +: SZ_W];
        size_ok  = (cmd_size != '0) && (cmd_size <= SZ_W'(LANES));
        cmd_hit  = ctl_wr && (ctl_sel == SEL_CMD);
        stat_rd  = ctl_rd && (ctl_sel == SEL_STAT);

        if (ctl_wr && ctl_sel == SEL_DATA)
            d.data = ctl_wdata[CTL_W-1 -: DATA_W];

        unique case (q.st)
            ST_IDLE: begin
                if (cmd_hit) begin
                    if (size_ok) begin
                        d.st       = ST_REQ;
                        d.op.write = ctl_wdata[CMD_WR];
                        d.op.size  = cmd_size;
                        d.op.addr  = ctl_wdata[ADDR_W-1:0];
                        d.op.wdata = ctl_wdata[CMD_WR] ? q.data : '0;
                    end else begin
                        fin              = 1'b1;
                        fin_stat[ST_DONE] = 1'b1;
                        fin_stat[ST_SZE]  = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    d.st = ST_RSP;
                end else if (expire) begin
                    fin              = 1'b1;
                    fin_stat[ST_DONE] = 1'b1;
                    fin_stat[ST_TOUT] = 1'b1;
                end
            end
            ST_RSP: begin
                if (rsp_valid) begin
                    fin              = 1'b1;
                    fin_stat[ST_DONE] = 1'b1;
                    fin_stat[ST_BERR] = rsp_err;
                    if (!q.op.write && !rsp_err)
                        fin_stat[DATA_W-1:0] = rd_masked;
                end else if (expire) begin
                    fin              = 1'b1;
                    fin_stat[ST_DONE] = 1'b1;
                    fin_stat[ST_TOUT] = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (fin) begin
            d.st   = ST_IDLE;
            d.stat = fin_stat;
        end else if (stat_rd) begin
            d.stat = '0;
        end
    end

    always_comb begin
        unique case (ctl_sel)
            SEL_DATA: ctl_rdata = {q.data, {(CTL_W-DATA_W){1'b0}}};
            SEL_STAT: begin
                ctl_rdata          = q.stat;
                ctl_rdata[ST_BUSY] = busy;
            end
            default:  ctl_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.op   <= '0;
            q.data <= '0;
            q.stat <= '0;
        end else begin
            q <= d;
        end
    end

    // request fields hold until accepted
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready && !expire |=> req_valid && $stable(req_addr) && $stable(req_size));
    // leaving busy always leaves a done flag behind
    p_done_on_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> q.stat[ST_DONE]);
    // status read clears the word
    p_clear_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !fin |=> (q.stat == '0));
    // an illegal size never reaches the bus
    p_bad_size_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_hit && !size_ok |=> !req_valid && q.stat[ST_SZE]);
    // commands during an access leave it untouched
    p_busy_ignores_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_hit |=> $stable(q.op));
endmodule

// File: tb/sim_ibb_bridge.sv
module sim_ibb_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int TOUT       = 16;
    localparam logic [63:0] DONE = 64'h8000_0000_0000_0000;
    localparam logic [63:0] BERR = 64'h4000_0000_0000_0000;
    localparam logic [63:0] TMO  = 64'h2000_0000_0000_0000;
    localparam logic [63:0] SZE  = 64'h1000_0000_0000_0000;
    localparam logic [63:0] BUSY = 64'h0800_0000_0000_0000;
    localparam logic [31:0] BUS_RD = 32'hA1B2_C3D4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        ctl_wr = 1'b0, ctl_rd = 1'b0;
    logic [1:0]  ctl_sel = 2'd0;
    logic [63:0] ctl_wdata = '0, ctl_rdata;
    logic        req_valid, req_ready = 1'b0, req_write;
    logic [31:0] req_addr, req_wdata;
    logic [2:0]  req_size;
    logic        rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0] rsp_rdata = '0;

    int checks = 0, errors = 0;
    logic [67:0] exp_q[$];
    int  bus_delay = 1;
    bit  bus_en = 1'b1, bus_err = 1'b0;
    int  wait_cnt = 0;
    logic [63:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    ibb_bridge #(.TIMEOUT(TOUT)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_sel(ctl_sel),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] mk_cmd(input logic w, input logic [2:0] sz, input logic [31:0] a);
        return {w, 12'b0, sz, 16'b0, a};
    endfunction

    task automatic ctl_write(input logic [1:0] sel, input logic [63:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_sel = sel; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic ctl_read(input logic [1:0] sel, output logic [63:0] v);
        @(negedge clk);
        ctl_rd = 1'b1; ctl_sel = sel;
        #1 v = ctl_rdata;
        @(negedge clk);
        ctl_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: expected request into the scoreboard, then the command
    task automatic issue(input logic w, input logic [2:0] sz, input logic [31:0] a,
                         input logic [31:0] exp_wd, input bit expect_req);
        if (expect_req) exp_q.push_back({w, a, sz, exp_wd});
        ctl_write(2'd1, mk_cmd(w, sz, a));
    endtask

    // bus responder and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            rsp_valid = 1'b0;
            if (req_ready) begin
                req_ready = 1'b0;
                wait_cnt  = bus_delay;
            end
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    rsp_valid = 1'b1;
                    rsp_err   = bus_err;
                    rsp_rdata = BUS_RD;
                end
            end
            if (req_valid && bus_en && wait_cnt == 0 && !rsp_valid) begin
                req_ready = 1'b1;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R3 unexpected request got %h expected none",
                             {req_write, req_addr, req_size, req_wdata});
                end else begin
                    logic [67:0] e;
                    e = exp_q.pop_front();
                    if ({req_write, req_addr, req_size, req_wdata} !== e) begin
                        errors++;
                        $display("FAIL R3/R4 request got %h expected %h",
                                 {req_write, req_addr, req_size, req_wdata}, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got timeout expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 req_valid", {63'b0, req_valid}, 64'b0);
        ctl_read(2'd2, rv); check("R1 status", rv, 64'b0);
        ctl_read(2'd0, rv); check("R1 data", rv, 64'b0);

        // R2 data register in upper half
        ctl_write(2'd0, 64'h1122_3344_DEAD_BEEF);
        ctl_read(2'd0, rv); check("R2 data readback", rv, 64'h1122_3344_0000_0000);

        // R3/R4/R5 full write
        issue(1'b1, 3'd4, 32'h0000_1000, 32'h1122_3344, 1'b1);
        idle(4);
        ctl_read(2'd2, rv); check("R5 write done", rv, DONE);
        ctl_read(2'd2, rv); check("R6 cleared", rv, 64'b0);

        // R4 partial write, upper lanes only
        issue(1'b1, 3'd2, 32'h0000_2002, 32'h1122_0000, 1'b1);
        idle(4);
        ctl_read(2'd2, rv); check("R5 partial write done", rv, DONE);

        // R5 reads of different sizes
        issue(1'b0, 3'd1, 32'h0000_0020, 32'h0, 1'b1);
        idle(4);
        ctl_read(2'd2, rv); check("R5 read size1", rv, DONE | 64'hA100_0000);
        issue(1'b0, 3'd3, 32'h0000_0024, 32'h0, 1'b1);
        idle(4);
        ctl_read(2'd2, rv); check("R5 read size3", rv, DONE | 64'hA1B2_C300);
        issue(1'b0, 3'd4, 32'h0000_0028, 32'h0, 1'b1);
        idle(4);
        ctl_read(2'd2, rv); check("R5 read size4", rv, DONE | 64'hA1B2_C3D4);
        check("R3 queue drained", 64'(exp_q.size()), 64'd0);

        // R7 illegal sizes
        issue(1'b1, 3'd0, 32'h0000_0030, 32'h0, 1'b0);
        idle(2);
        check("R7 no request size0", {63'b0, req_valid}, 64'b0);
        ctl_read(2'd2, rv); check("R7 size0 error", rv, DONE | SZE);
        issue(1'b0, 3'd5, 32'h0000_0034, 32'h0, 1'b0);
        idle(2);
        ctl_read(2'd2, rv); check("R7 size5 error", rv, DONE | SZE);

        // R8 bus error on read
        bus_err = 1'b1;
        issue(1'b0, 3'd4, 32'h0000_0040, 32'h0, 1'b1);
        idle(4);
        ctl_read(2'd2, rv); check("R8 bus error", rv, DONE | BERR);
        bus_err = 1'b0;

        // R10 busy flag and ignored command
        bus_delay = 8;
        issue(1'b0, 3'd4, 32'h0000_0044, 32'h0, 1'b1);
        ctl_read(2'd2, rv); check("R10 busy shown", rv, BUSY);
        ctl_write(2'd1, mk_cmd(1'b1, 3'd4, 32'h0000_0099));
        idle(15);
        ctl_read(2'd2, rv); check("R10 original op result", rv, DONE | 64'hA1B2_C3D4);
        check("R10 no second request", 64'(exp_q.size()), 64'd0);
        bus_delay = 1;

        // R9 timeout with the bus never ready
        bus_en = 1'b0;
        issue(1'b1, 3'd4, 32'h0000_0050, 32'h1122_3344, 1'b0);
        idle(8);
        ctl_read(2'd2, rv); check("R9 still busy mid-window", rv, BUSY);
        idle(12);
        check("R9 request dropped", {63'b0, req_valid}, 64'b0);
        ctl_read(2'd2, rv); check("R9 timeout flag", rv, DONE | TMO);
        ctl_read(2'd2, rv); check("R6 cleared after timeout", rv, 64'b0);
        bus_en = 1'b1;

        // bridge usable again after timeout
        issue(1'b0, 3'd2, 32'h0000_0060, 32'h0, 1'b1);
        idle(4);
        ctl_read(2'd2, rv); check("R5 read after timeout", rv, DONE | 64'hA1B2_0000);

        idle(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule